// File: doc/BRIEF.md
# Grouped Prescaler and Binary Divider Tick Stage

This block turns one input clock into five count-enable tick streams for a bank of timer channels. Two programmable 8-bit prescalers each serve a group of channels: the first drives channels 0 and 1, the second drives channels 2, 3 and 4. After its group prescaler, every channel has a power-of-two divider chosen by a 4-bit select code. Each tick is a one-cycle pulse in the input clock domain, so downstream counters stay synchronous and no derived clock exists.

Software programs the stage through a small register port with two words. The prescale word carries both prescaler values. The divide word carries the five select codes. The select code is a log2 value offset by a base that depends on the variant. The narrow (16-bit counter) variant has a base of 1, so its smallest divisor is 2. The wide (32-bit counter) variant has a base of 0, so its smallest divisor is 1. Any register write restarts every prescaler and divider, so the first tick after a write falls at a known cycle.

Top module: `tick_stage`

## Requirements
- R1: Address 0 holds the prescale word. Bits 7:0 are prescaler A and bits 15:8 are prescaler B. Read bits 31:16 return zero. A cycle without wr_en_i leaves the word unchanged.
- R2: Address 1 holds the divide word. Channel c's select code sits in bits 4c+3:4c. Read bits 31:20 return zero.
- R3: A prescaler field value N gives one prescaler pulse every N+1 input cycles.
- R4: Channels 0 and 1 are paced by prescaler A. Channels 2, 3 and 4 are paced by prescaler B.
- R5: A select code s gives divisor 2^(s+BASE). BASE is 0 for the wide variant (NARROW=0) and 1 for the narrow variant (NARROW=1).
- R6: When s+BASE is greater than 4, the divisor saturates to 16.
- R7: Each tick_o bit is a single-cycle pulse. It repeats every (N+1)*D input cycles, where N is the group's prescale value and D is the channel's divisor.
- R8: A write to either address restarts all prescalers and dividers. The first tick of a channel appears (N+1)*D cycles after the clock edge that takes the write.
- R9: During reset all ticks are low and both words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Word select: 0 = prescale word, 1 = divide word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word at addr_i |
| tick_o | output | 5 | One count-enable pulse per channel |

## Verification
The hardest case is the exact phase of the first tick after reprogramming, because a write can land in the middle of a partial prescale or divide count. The bench sets the divide word and then the prescale word. From the edge that takes the final write, it predicts every tick of every channel across a window. Any tick that arrives early, arrives late or is missing is caught cycle by cycle. The stimulus uses distinct prescale values for the two groups, all five divisor codes at once, and over-range codes, so each channel's period identifies its group and its divisor.

// File: rtl/tick_pkg.sv
package tick_pkg;
  // log2 of the divisor, clipped to the largest stage
  function automatic int unsigned sat_log2(input int unsigned code,
                                           input int unsigned base,
                                           input int unsigned lmax);
    int unsigned s;
    s = code + base;
    return (s > lmax) ? lmax : s;
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reload_i,
  input  logic [PS_W-1:0] load_val_i,
  input  logic [PS_W-1:0] field_i,
  output logic            pulse_o
);
  logic [PS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (reload_i)          cnt_q <= load_val_i;
    else if (cnt_q == '0)       cnt_q <= field_i;
    else                        cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q == '0);

  AST_PS_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> cnt_q <= field_i); // R3
  AST_PS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && field_i != '0 && !reload_i) |=> !pulse_o); // R3
endmodule

// File: rtl/tick_divider.sv
module tick_divider
  import tick_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int LOG_MAX = 4,
  parameter int BASE = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             pulse_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (LOG_MAX < 1) ? 1 : LOG_MAX;

  logic [CNT_W-1:0] cnt_q, lim;
  logic             last, tick_q;

  always_comb begin
    int unsigned lg;
    lg  = sat_log2(int'(sel_i), BASE, LOG_MAX);
    lim = CNT_W'((1 << lg) - 1);
  end

  assign last = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= pulse_i && last && !clr_i;
      if (clr_i)        cnt_q <= '0;
      else if (pulse_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q <= lim); // R5
  AST_TICK_FROM_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(pulse_i)); // R7
endmodule

// File: rtl/tick_stage.sv
module tick_stage #(
  parameter int NUM_CH  = 5,
  parameter int GRP0_CH = 2,
  parameter int PS_W    = 8,
  parameter int SEL_W   = 4,
  parameter int LOG_MAX = 4,
  parameter int DATA_W  = 32,
  parameter bit NARROW  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] tick_o
);
  localparam int CFG0_W = 2 * PS_W;
  localparam int CFG1_W = NUM_CH * SEL_W;
  localparam int BASE   = NARROW ? 1 : 0;

  logic [CFG0_W-1:0] cfg0_q;
  logic [CFG1_W-1:0] cfg1_q;
  logic              wr0, wr1, restart;
  logic [1:0]        ps_pulse;

  assign wr0     = wr_en_i && (addr_i == 1'b0);
  assign wr1     = wr_en_i && (addr_i == 1'b1);
  assign restart = wr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
    end else begin
      if (wr0) cfg0_q <= wdata_i[CFG0_W-1:0];
      if (wr1) cfg1_q <= wdata_i[CFG1_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i) rdata_o[CFG1_W-1:0] = cfg1_q;
    else        rdata_o[CFG0_W-1:0] = cfg0_q;
  end

  // Reload value tracks the word being written so the new count starts at once
  for (genvar g = 0; g < 2; g++) begin : g_ps
    logic [PS_W-1:0] load_val;
    assign load_val = wr0 ? wdata_i[g*PS_W +: PS_W] : cfg0_q[g*PS_W +: PS_W];
    tick_prescaler #(.PS_W(PS_W)) u_ps (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .reload_i   (restart),
      .load_val_i (load_val),
      .field_i    (cfg0_q[g*PS_W +: PS_W]),
      .pulse_o    (ps_pulse[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int GRP = (c < GRP0_CH) ? 0 : 1;
    tick_divider #(.SEL_W(SEL_W), .LOG_MAX(LOG_MAX), .BASE(BASE)) u_div (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (restart),
      .pulse_i (ps_pulse[GRP]),
      .sel_i   (cfg1_q[c*SEL_W +: SEL_W]),
      .tick_o  (tick_o[c])
    );
  end

  AST_CFG0_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr0 |=> $stable(cfg0_q)); // R1
  AST_CFG1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr1 |=> $stable(cfg1_q)); // R2
  AST_NO_TICK_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> tick_o == '0); // R8
endmodule

// File: tb/tick_stage_bench.sv
module tick_stage_bench;
  localparam int NCH = 5;
  localparam int BASE = 0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] tick;

  int tests = 0, fails = 0;
  int ncyc = 0;
  int win_lo = 0, win_hi = -1;
  int exp_q [NCH][$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tick_stage u_tick_stage (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tick_o(tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int divisor(input int code);
    int lg;
    lg = code + BASE;
    if (lg > 4) lg = 4;
    return 1 << lg;
  endfunction

  // Monitor: compare each tick against the scoreboard inside the armed window
  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (ncyc > win_lo && ncyc <= win_hi) begin
      for (int c = 0; c < NCH; c++) begin
        bool_check(c);
      end
    end
  end

  task automatic bool_check(input int c);
    bit due;
    due = (exp_q[c].size() > 0) && (exp_q[c][0] == ncyc);
    if (due) void'(exp_q[c].pop_front());
    chk(tick[c] == due, $sformatf("R7/R8 ch%0d cyc%0d", c, ncyc), tick[c], due);
  endtask

  task automatic wr(input logic a, input logic [31:0] d, output int n);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d; n = ncyc;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge clk); #1;
    addr = a; #1;
    d = rdata;
  endtask

  // Driver: program both words, push expected tick cycles, run the window
  task automatic run(input int psa, input int psb, input logic [19:0] codes, input int win);
    int n;
    win_hi = -1;
    for (int c = 0; c < NCH; c++) exp_q[c].delete();
    wr(1'b1, {12'h0, codes}, n);
    wr(1'b0, {16'h0, psb[7:0], psa[7:0]}, n);
    for (int c = 0; c < NCH; c++) begin
      int per, t;
      per = ((c < 2) ? psa + 1 : psb + 1) * divisor(int'(codes[4*c +: 4]));
      t = n + 1 + per;
      while (t <= n + win) begin
        exp_q[c].push_back(t);
        t += per;
      end
    end
    win_lo = n; win_hi = n + win;
    repeat (win + 2) @(negedge clk);
    win_hi = -1;
    for (int c = 0; c < NCH; c++)
      chk(exp_q[c].size() == 0, $sformatf("R7 ch%0d missing ticks", c), exp_q[c].size(), 0);
  endtask

  initial begin
    logic [31:0] d;
    int n;
    #3;
    chk(tick == '0, "R9 ticks in reset", tick, 0);
    chk(rdata == 32'h0, "R9 word0 in reset", rdata, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b1, d); chk(d == 32'h0, "R9 word1 after reset", d, 0);

    // R3/R7: fastest case, tick every cycle
    run(0, 0, 20'h00000, 20);
    // R4/R5: distinct groups, all codes 0..4
    run(2, 4, {4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, 300);
    // R3/R4: swapped group speeds
    run(5, 0, {4'd3, 4'd0, 4'd1, 4'd2, 4'd4}, 300);
    // R6: over-range codes saturate to 16
    run(1, 3, {4'd4, 4'd9, 4'd15, 4'd7, 4'd5}, 200);
    // R8: immediate reprogram mid-count
    run(6, 2, {4'd1, 4'd2, 4'd0, 4'd3, 4'd2}, 150);

    // R1/R2: readback and field masking
    wr(1'b0, 32'hABCD_1234, n);
    rd(1'b0, d); chk(d == 32'h0000_1234, "R1 word0 readback", d, 32'h1234);
    wr(1'b1, 32'hFFFF_FFFF, n);
    rd(1'b1, d); chk(d == 32'h000F_FFFF, "R2 word1 readback", d, 32'hFFFFF);
    @(negedge clk); #1; wr_en = 1'b0; addr = 1'b0; wdata = 32'h0000_5555;
    @(negedge clk);
    rd(1'b0, d); chk(d == 32'h0000_1234, "R1 no write without strobe", d, 32'h1234);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule